// File: doc/BRIEF.md
# Retriggerable Clocked One-Shot

This block is a synchronous pulse stretcher. It works like a retriggerable monostable but counts clock cycles in place of an RC time constant. It watches two trigger inputs. `trigFallIn` fires on a falling edge and `trigRiseIn` fires on a rising edge, and each input also serves as an inhibit for the other. A qualified trigger loads a down-counter with the programmed length, and the output `q` stays high until that counter empties. A trigger that arrives while a pulse is running reloads the counter, so the pulse lasts a full interval from the latest trigger.

An active-low functional clear (`clearN`) empties the counter and gates `q` low at once. Releasing the clear never starts a pulse. Both trigger inputs pass through a synchronizer before edge detection. The block ignores edges until the synchronizer pipeline holds real samples after the system reset. The complementary output `qN` is always the inverse of `q`.

Top module: `oneshot_pulse`

## Requirements
- R1: A falling edge on `trigFallIn` is a valid trigger when `trigRiseIn` is high and `clearN` is high.
- R2: A rising edge on `trigRiseIn` is a valid trigger when `trigFallIn` is low and `clearN` is high.
- R3: While `clearN` is 0, `q` is 0 and `qN` is 1 in the same cycle, whatever the trigger inputs do, and any running pulse is cancelled.
- R4: A 0-to-1 change of `clearN` never starts a pulse, even when the trigger inputs sit at a triggering level pair.
- R5: A falling edge on `trigFallIn` while `trigRiseIn` is low, or a rising edge on `trigRiseIn` while `trigFallIn` is high, produces no pulse.
- R6: After a valid trigger, `q` is high for exactly `pulseLen` clock cycles, and a `pulseLen` of 0 gives 1 cycle. `q` rises on the third rising clock edge after the input change: two synchronizer edges plus the load edge, whatever `pulseLen` is.
- R7: A valid trigger during a pulse restarts the interval, so `q` stays high for `pulseLen` cycles counted from the retrigger.
- R8: After system reset, and whenever no pulse is running, `q` is 0 and `qN` is 1.
- R9: `qN` equals the inverse of `q` on every cycle, including during reset.
- R10: `pulseLen` is sampled only when a trigger is accepted, so changing it during a pulse does not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| clearN | input | 1 | Active-low functional clear, synchronous to `clk` |
| trigFallIn | input | 1 | Trigger input active on a falling edge; held high it inhibits |
| trigRiseIn | input | 1 | Trigger input active on a rising edge; held low it inhibits |
| pulseLen | input | 16 | Pulse length in clock cycles (0 treated as 1) |
| q | output | 1 | True pulse output |
| qN | output | 1 | Complement of `q` |

## Verification
If the counter held a stale nonzero value, the pulse would run too long. That shows on `q` on the cycle the pulse should have ended, or as a pulse that appears with no trigger. A wrongly qualified edge shows three cycles after the input change, as a missing pulse or as a pulse where an inhibit should have held. A clear gate that failed, or a counter that kept its value through clear, shows on the very next sample during clear or as a pulse after clear is released. A length latched at the wrong time shows only at the falling edge of `q`, so every pulse-width check measures up to that edge.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef struct packed {
    logic load;   // accept a trigger: reload the interval counter
    logic clear;  // functional clear: empty the counter
  } osStrobe_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] curOut,
  output logic [WIDTH-1:0] prevOut,
  output logic             primed
);
  localparam int FILL   = STAGES + 1;
  localparam int FILL_W = $clog2(FILL + 1);

  logic [FILL_W-1:0] fillCnt;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic [STAGES:0] chain;  // [STAGES-1:0] synchronizer, [STAGES] previous sample
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-1:0], rawIn[gi]};
      end
      assign curOut[gi]  = chain[STAGES-1];
      assign prevOut[gi] = chain[STAGES];
    end
  endgenerate

  // Edges are ignored until every stage holds a real sample.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          fillCnt <= '0;
    else if (fillCnt != FILL_W'(FILL))  fillCnt <= fillCnt + 1'b1;
  end
  assign primed = (fillCnt == FILL_W'(FILL));
endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
(
  input  logic      clearN,
  input  logic      primed,
  input  logic      fallCur,
  input  logic      fallPrev,
  input  logic      riseCur,
  input  logic      risePrev,
  output osStrobe_t strobe
);
  logic fallQual;
  logic riseQual;

  always_comb begin
    fallQual     = fallPrev & ~fallCur & riseCur;    // falling edge, other input high
    riseQual     = ~risePrev & riseCur & ~fallCur;   // rising edge, other input low
    strobe.clear = ~clearN;
    strobe.load  = clearN & primed & (fallQual | riseQual);
  end
endmodule

// File: rtl/oneshot_dpath.sv
module oneshot_dpath
  import oneshot_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearN,
  input  osStrobe_t        strobe,
  input  logic [LEN_W-1:0] pulseLen,
  output logic             qOut,
  output logic             qnOut
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] count;
  logic [LEN_W-1:0] loadVal;

  assign loadVal = (pulseLen == '0) ? ONE : pulseLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (strobe.clear)  count <= '0;
    else if (strobe.load)   count <= loadVal;
    else if (count != '0)   count <= count - ONE;
  end

  assign qOut  = (count != '0) & clearN;
  assign qnOut = ~qOut;
endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
  import oneshot_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearN,
  input  logic             trigFallIn,
  input  logic             trigRiseIn,
  input  logic [LEN_W-1:0] pulseLen,
  output logic             q,
  output logic             qN
);
  localparam int N_TRIG = 2;

  logic [N_TRIG-1:0] cur;
  logic [N_TRIG-1:0] prev;
  logic              primed;
  osStrobe_t         strobe;
  logic              trigFire;

  edge_sync #(.WIDTH(N_TRIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .rawIn({trigRiseIn, trigFallIn}),
    .curOut(cur), .prevOut(prev), .primed(primed)
  );

  oneshot_ctrl u_ctrl (
    .clearN(clearN), .primed(primed),
    .fallCur(cur[0]), .fallPrev(prev[0]),
    .riseCur(cur[1]), .risePrev(prev[1]),
    .strobe(strobe)
  );

  oneshot_dpath #(.LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .clearN(clearN), .strobe(strobe),
    .pulseLen(pulseLen), .qOut(q), .qnOut(qN)
  );

  assign trigFire = strobe.load;
endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk (
  input logic clk,
  input logic rstN,
  input logic clearN,
  input logic q,
  input logic qN,
  input logic trigFire
);
  // R3: clear forces the idle output pair in the same cycle
  a_r3_clear_forces_idle: assert property (@(posedge clk) disable iff (!rstN)
    !clearN |-> (!q && qN));

  // R4: releasing clear does not produce a pulse
  a_r4_release_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clearN) |-> !q);

  // R7: an accepted trigger gives a high output on the next cycle
  a_r7_trigger_sets_q: assert property (@(posedge clk) disable iff (!rstN)
    trigFire |=> (q || !clearN));

  // R8: with no trigger, an idle output stays idle
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!q && !trigFire) |=> !q);

  // R6: a pulse cannot end right after a trigger was accepted
  a_r6_no_end_after_load: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(q) && clearN && $past(clearN)) |-> !$past(trigFire));
endmodule

bind oneshot_pulse oneshot_chk u_chk (
  .clk(clk), .rstN(rstN), .clearN(clearN), .q(q), .qN(qN), .trigFire(trigFire)
);

// File: tb/sim_oneshot_pulse.sv
module sim_oneshot_pulse;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearN = 1'b1;
  logic        trigFallIn = 1'b1;
  logic        trigRiseIn = 1'b0;
  logic [15:0] pulseLen = 16'd4;
  logic        q;
  logic        qN;

  int total = 0;
  int bad = 0;
  int compErr = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  oneshot_pulse u0 (
    .clk(clk), .rstN(rstN), .clearN(clearN), .trigFallIn(trigFallIn),
    .trigRiseIn(trigRiseIn), .pulseLen(pulseLen), .q(q), .qN(qN)
  );

  typedef struct packed {
    logic        useRise;   // 0: falling edge on trigFallIn, 1: rising edge on trigRiseIn
    logic        otherLvl;  // level held on the other input
    logic [15:0] len;
    logic [15:0] expW;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 16'd5,  16'd5},   // R1
    '{1'b0, 1'b1, 16'd1,  16'd1},   // R1, R6 shortest
    '{1'b0, 1'b1, 16'd0,  16'd1},   // R6 zero length
    '{1'b0, 1'b0, 16'd5,  16'd0},   // R5 inhibit by rise input low
    '{1'b1, 1'b0, 16'd7,  16'd7},   // R2
    '{1'b1, 1'b1, 16'd7,  16'd0},   // R5 inhibit by fall input high
    '{1'b1, 1'b0, 16'd0,  16'd1},   // R2, R6 zero length
    '{1'b0, 1'b1, 16'd40, 16'd40}   // R6 long
  };

  // R9: complement monitor on every negative edge, reset included
  always @(negedge clk) if (q !== ~qN) compErr++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_idle();
    trigRiseIn = 1'b0;
    tick(1);
    trigFallIn = 1'b1;
    tick(60);
  endtask

  // Edge driven at the current negative edge; measures the high run of q.
  task automatic measure(input string req, input logic [15:0] expW);
    int w;
    tick(2);
    check({req, " q low before third edge"}, 32'(q), 32'd0);
    tick(1);
    w = 0;
    while (q && w < 300) begin
      w++;
      tick(1);
    end
    check({req, " width"}, 32'(w), 32'(expW));
  endtask

  initial begin
    tick(3);
    check("R8 reset q", 32'(q), 32'd0);
    check("R8 reset qN", 32'(qN), 32'd1);
    rstN = 1'b1;
    tick(8);
    check("R8 idle q", 32'(q), 32'd0);

    for (int i = 0; i < NV; i++) begin
      pulseLen = VEC[i].len;
      if (!VEC[i].useRise) begin
        trigRiseIn = VEC[i].otherLvl;
        tick(5);
        trigFallIn = 1'b0;
        measure(VEC[i].otherLvl ? "R1/R6" : "R5", VEC[i].expW);
      end else begin
        trigFallIn = VEC[i].otherLvl;
        tick(5);
        trigRiseIn = 1'b1;
        measure(VEC[i].otherLvl ? "R5" : "R2/R6", VEC[i].expW);
      end
      go_idle();
    end

    // R7: retrigger restarts the full interval with the newly sampled length
    pulseLen = 16'd10;
    trigRiseIn = 1'b1;
    tick(5);
    trigFallIn = 1'b0;          // t0
    tick(4);
    trigFallIn = 1'b1;          // t0+4
    pulseLen = 16'd12;
    tick(2);
    trigFallIn = 1'b0;          // t0+6, retrigger loads at t0+9
    tick(7);
    check("R7 high past first interval", 32'(q), 32'd1);   // t0+13
    tick(7);
    check("R7 high at end of restart", 32'(q), 32'd1);     // t0+20
    tick(1);
    check("R7 low after restart", 32'(q), 32'd0);          // t0+21
    go_idle();

    // R10: length change during a pulse is ignored
    pulseLen = 16'd8;
    trigRiseIn = 1'b1;
    tick(5);
    trigFallIn = 1'b0;          // t0
    tick(4);
    pulseLen = 16'd30;
    tick(6);
    check("R10 high last cycle", 32'(q), 32'd1);           // t0+10
    tick(1);
    check("R10 low after old length", 32'(q), 32'd0);      // t0+11
    go_idle();

    // R3: clear cancels a running pulse at once and blocks triggers
    pulseLen = 16'd20;
    trigRiseIn = 1'b1;
    tick(5);
    trigFallIn = 1'b0;
    tick(6);
    check("R3 pulse running", 32'(q), 32'd1);
    clearN = 1'b0;
    #1;
    check("R3 q forced low", 32'(q), 32'd0);
    check("R3 qN forced high", 32'(qN), 32'd1);
    trigFallIn = 1'b1;
    tick(2);
    trigFallIn = 1'b0;          // would trigger if clear were high
    tick(8);
    check("R3 no pulse during clear", 32'(q), 32'd0);
    // R4: release with a triggering level pair (fall input low, rise input high)
    clearN = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 30; k++) begin
        tick(1);
        if (q) seen++;
      end
      check("R4 no pulse from clear release", 32'(seen), 32'd0);
    end
    // A real edge after release still works
    pulseLen = 16'd3;
    trigFallIn = 1'b1;
    tick(4);
    trigFallIn = 1'b0;
    measure("R1 after clear", 16'd3);
    go_idle();

    check("R9 complement every cycle", 32'(compErr), 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule